// File: doc/BRIEF.md
# Resumable Block-Copy Engine

This engine copies a block of bytes inside the processor while the control unit waits. It is not given its arguments on ports. When started, it reads six parameter bytes from memory beginning at the stack pointer plus an 8-bit operand offset. It then moves data with a two-cycle loop: one cycle reads a byte and the next cycle writes it. Within each field the low byte comes first. Copying runs from the highest index down to index zero. A count value of N therefore moves N+1 bytes.

An interrupt stops the engine at any point of a run. A resume flag records whether all six parameters had been fetched. If the flag is set, the next start goes straight back into the copy loop, using the working count, source and destination it held at the stop. An abort clears the flag, so the next start fetches the parameters again. When the last byte has been written, the engine raises a one-cycle completion pulse and goes idle. An interrupt that arrives in that completion cycle does not turn it into a restart.

Top module: `blkmove_engine`

## Requirements
- R1: While reset is asserted and after it is released, mem_rd_o, mem_wr_o and done_o are low. The resume flag is clear, so the first start fetches parameters.
- R2: A start with the resume flag clear reads six bytes in six consecutive cycles, at addresses sp_i+ofs_i+0 through +5. In order they are count low, count high, source low, source high, destination low and destination high. The resume flag is set on the cycle of the sixth read.
- R3: The copy loop reads at source+count. In the next cycle it writes that byte to destination+count. A count of N moves exactly the bytes at indices N down to 0 and leaves index N+1 of the destination untouched.
- R4: done_o is high for exactly one cycle, in the cycle after the write at index 0. In the following cycle no strobe is active.
- R5: When irq_i is high during a fetch, read or write cycle, that cycle's strobe is suppressed and the engine goes idle. The count is kept. If the resume flag was set, the next start begins with a read at source+count, with no parameter fetch.
- R6: An interrupt during the parameter fetch leaves the resume flag clear. The next start fetches again from offset 0.
- R7: An abort clears the resume flag. The next start fetches parameters again.
- R8: An interrupt in the completion cycle does not suppress done_o. The resume flag stays clear.
- R9: The parameter address sp_i+ofs_i+k is formed modulo 2^16, with ofs_i zero-extended.
- R10: A start pulse while the engine is active has no effect on the run.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Begin or resume a block copy (sampled when idle) |
| sp_i | input | 16 | Current stack pointer, read only |
| ofs_i | input | 8 | Operand offset added to the stack pointer |
| irq_i | input | 1 | Interrupt: stop and keep resume state |
| abort_i | input | 1 | Abort: stop and clear resume state |
| mem_rdata_i | input | 8 | Read data, valid in the same cycle as mem_rd_o |
| mem_addr_o | output | 16 | Memory address |
| mem_wdata_o | output | 8 | Write data |
| mem_rd_o | output | 1 | Read strobe |
| mem_wr_o | output | 1 | Write strobe |
| done_o | output | 1 | One-cycle completion pulse to the control unit |

## Verification
The assertions assume that read data is returned combinationally in the strobe cycle. They also assume that sp_i and ofs_i are held steady from start until the parameter fetch ends. The stimulus drives all inputs at the falling edge and keeps sp_i and ofs_i constant for a whole run. The bench places parameter, source and destination areas in disjoint address windows, so a copied byte never overwrites a parameter or a source byte. The random runs draw counts, offsets and areas from bounded ranges that keep those windows apart, including when the 16-bit parameter address wraps.

// File: rtl/blkmove_pkg.sv
package blkmove_pkg;
  typedef enum logic [2:0] {
    ST_IDLE  = 3'd0,
    ST_PARM  = 3'd1,
    ST_READ  = 3'd2,
    ST_WRITE = 3'd3,
    ST_DONE  = 3'd4
  } bm_state_e;
endpackage

// File: rtl/blkmove_ctrl.sv
module blkmove_ctrl
  import blkmove_pkg::*;
#(
  parameter int NPAR = 6,
  localparam int IW = $clog2(NPAR)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start_i,
  input  logic          irq_i,
  input  logic          abort_i,
  input  logic          cnt_zero_i,
  output bm_state_e     state_o,
  output logic [IW-1:0] idx_o,
  output logic          halt_o
);
  localparam logic [IW-1:0] LAST = IW'(NPAR - 1);

  bm_state_e     st_q, st_d;
  logic [IW-1:0] idx_q, idx_d;
  logic          busy_q, busy_d;
  logic          active, go, idx_en;

  assign active = (st_q == ST_PARM) || (st_q == ST_READ) || (st_q == ST_WRITE);
  assign halt_o = active && (irq_i || abort_i);
  assign go     = start_i && !irq_i && !abort_i;
  assign idx_en = (st_q == ST_IDLE) || (st_q == ST_PARM);

  always_comb begin
    st_d   = st_q;
    idx_d  = idx_q;
    busy_d = busy_q;
    unique case (st_q)
      ST_IDLE: if (go) begin
        idx_d = '0;
        st_d  = busy_q ? ST_READ : ST_PARM;
      end
      ST_PARM: begin
        if (halt_o) st_d = ST_IDLE;
        else if (idx_q == LAST) begin
          st_d   = ST_READ;
          busy_d = 1'b1;
        end else idx_d = idx_q + 1'b1;
      end
      ST_READ:  st_d = halt_o ? ST_IDLE : ST_WRITE;
      ST_WRITE: begin
        if (halt_o) st_d = ST_IDLE;
        else if (cnt_zero_i) begin
          st_d   = ST_DONE;
          busy_d = 1'b0;
        end else st_d = ST_READ;
      end
      ST_DONE:  st_d = ST_IDLE;
      default:  st_d = ST_IDLE;
    endcase
    if (abort_i) busy_d = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= ST_IDLE;
      idx_q  <= '0;
      busy_q <= 1'b0;
    end else begin
      st_q   <= st_d;
      busy_q <= busy_d;
      if (idx_en) idx_q <= idx_d;
    end
  end

  assign state_o = st_q;
  assign idx_o   = idx_q;

  assert_busy_set_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == ST_PARM && idx_q == LAST && !halt_o) |=> busy_q);
  assert_halt_idle_R5: assert property (@(posedge clk) disable iff (!rst_n)
    halt_o |=> (st_q == ST_IDLE));
  assert_resume_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == ST_IDLE && go && busy_q) |=> (st_q == ST_READ));
  assert_refetch_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == ST_IDLE && go && !busy_q) |=> (st_q == ST_PARM && idx_q == '0));
  assert_abort_clear_R7: assert property (@(posedge clk) disable iff (!rst_n)
    abort_i |=> !busy_q);
  assert_done_pulse_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == ST_DONE) |=> (st_q == ST_IDLE));
  assert_done_clear_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == ST_DONE) |-> !busy_q);
endmodule

// File: rtl/blkmove_path.sv
module blkmove_path
  import blkmove_pkg::*;
#(
  parameter int AW   = 16,
  parameter int DW   = 8,
  parameter int OW   = 8,
  parameter int NPAR = 6,
  localparam int IW = $clog2(NPAR),
  localparam int PB = AW / DW
) (
  input  logic          clk,
  input  logic          rst_n,
  input  bm_state_e     state_i,
  input  logic [IW-1:0] idx_i,
  input  logic          halt_i,
  input  logic [AW-1:0] sp_i,
  input  logic [OW-1:0] ofs_i,
  input  logic [DW-1:0] rdata_i,
  output logic [AW-1:0] addr_o,
  output logic [DW-1:0] wdata_o,
  output logic          rd_o,
  output logic          wr_o,
  output logic          cnt_zero_o
);
  logic [AW-1:0] cnt_q, cnt_d, src_q, src_d, dst_q, dst_d;
  logic [DW-1:0] tmp_q;
  logic          ld_en, rd_en, wr_en;

  assign ld_en = (state_i == ST_PARM)  && !halt_i;
  assign rd_en = (state_i == ST_READ)  && !halt_i;
  assign wr_en = (state_i == ST_WRITE) && !halt_i;
  assign cnt_zero_o = (cnt_q == '0);

  always_comb begin
    cnt_d = cnt_q;
    src_d = src_q;
    dst_d = dst_q;
    if (ld_en) begin
      for (int b = 0; b < PB; b++) begin
        if (idx_i == IW'(b))        cnt_d[b*DW +: DW] = rdata_i;
        if (idx_i == IW'(PB + b))   src_d[b*DW +: DW] = rdata_i;
        if (idx_i == IW'(2*PB + b)) dst_d[b*DW +: DW] = rdata_i;
      end
    end
    if (wr_en && !cnt_zero_o) cnt_d = cnt_q - 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      src_q <= '0;
      dst_q <= '0;
      tmp_q <= '0;
    end else begin
      if (ld_en || wr_en) cnt_q <= cnt_d;
      if (ld_en) begin
        src_q <= src_d;
        dst_q <= dst_d;
      end
      if (rd_en) tmp_q <= rdata_i;
    end
  end

  always_comb begin
    unique case (state_i)
      ST_PARM:  addr_o = sp_i + AW'(ofs_i) + AW'(idx_i);
      ST_READ:  addr_o = src_q + cnt_q;
      ST_WRITE: addr_o = dst_q + cnt_q;
      default:  addr_o = '0;
    endcase
  end

  assign rd_o    = ld_en || rd_en;
  assign wr_o    = wr_en;
  assign wdata_o = tmp_q;

  assert_cnt_dec_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_o && !cnt_zero_o) |=> (cnt_q == $past(cnt_q) - 1'b1));
  assert_wr_after_rd_R3: assert property (@(posedge clk) disable iff (!rst_n)
    wr_o |-> $past(rd_o));
  assert_cnt_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (state_i == ST_IDLE) |=> $stable(cnt_q));
endmodule

// File: rtl/blkmove_engine.sv
module blkmove_engine
  import blkmove_pkg::*;
#(
  parameter int AW   = 16,
  parameter int DW   = 8,
  parameter int OW   = 8,
  localparam int NPAR = 3 * (AW / DW),
  localparam int IW   = $clog2(NPAR)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start_i,
  input  logic [AW-1:0] sp_i,
  input  logic [OW-1:0] ofs_i,
  input  logic          irq_i,
  input  logic          abort_i,
  input  logic [DW-1:0] mem_rdata_i,
  output logic [AW-1:0] mem_addr_o,
  output logic [DW-1:0] mem_wdata_o,
  output logic          mem_rd_o,
  output logic          mem_wr_o,
  output logic          done_o
);
  bm_state_e     state;
  logic [IW-1:0] idx;
  logic          halt, cnt_zero;

  blkmove_ctrl #(.NPAR(NPAR)) u_ctrl (
    .clk(clk), .rst_n(rst_n), .start_i(start_i), .irq_i(irq_i),
    .abort_i(abort_i), .cnt_zero_i(cnt_zero), .state_o(state),
    .idx_o(idx), .halt_o(halt)
  );

  blkmove_path #(.AW(AW), .DW(DW), .OW(OW), .NPAR(NPAR)) u_path (
    .clk(clk), .rst_n(rst_n), .state_i(state), .idx_i(idx), .halt_i(halt),
    .sp_i(sp_i), .ofs_i(ofs_i), .rdata_i(mem_rdata_i), .addr_o(mem_addr_o),
    .wdata_o(mem_wdata_o), .rd_o(mem_rd_o), .wr_o(mem_wr_o),
    .cnt_zero_o(cnt_zero)
  );

  assign done_o = (state == ST_DONE);

  assert_done_quiet_R4: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |-> (!mem_rd_o && !mem_wr_o));
endmodule

// File: tb/blkmove_engine_tb.sv
module blkmove_engine_tb;
  logic        clk, rst_n, start, irq, abort;
  logic [15:0] sp, addr;
  logic [7:0]  ofs, rdata, wdata;
  logic        rd, wr, done;
  logic [7:0]  mem [0:4095];

  int total = 0, bad = 0;
  logic [15:0] fa;
  logic        frd, gated, idle_ok, dw_ok;
  logic [15:0] pa [0:5];
  int          dc;

  initial clk = 1'b0;
  always #4 clk = ~clk;

  assign rdata = mem[addr[11:0]];

  blkmove_engine u_dut (
    .clk(clk), .rst_n(rst_n), .start_i(start), .sp_i(sp), .ofs_i(ofs),
    .irq_i(irq), .abort_i(abort), .mem_rdata_i(rdata), .mem_addr_o(addr),
    .mem_wdata_o(wdata), .mem_rd_o(rd), .mem_wr_o(wr), .done_o(done)
  );

  task automatic chk(bit ok, string tag, int act, int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
    end
  endtask

  task automatic setup(logic [15:0] s, logic [7:0] o, logic [15:0] n,
                       logic [15:0] src, logic [15:0] dst);
    logic [7:0] pb [0:5];
    pb[0] = n[7:0];   pb[1] = n[15:8];
    pb[2] = src[7:0]; pb[3] = src[15:8];
    pb[4] = dst[7:0]; pb[5] = dst[15:8];
    for (int k = 0; k < 6; k++) begin
      logic [15:0] a;
      a = s + 16'(o) + 16'(k);
      mem[a[11:0]] = pb[k];
    end
    for (int i = 0; i <= int'(n) + 1; i++) begin
      logic [15:0] a;
      a = src + 16'(i);
      mem[a[11:0]] = 8'($urandom);
      a = dst + 16'(i);
      mem[a[11:0]] = 8'hEE;
    end
    sp = s;
    ofs = o;
  endtask

  // one run from a start pulse; irq/abort/start injected at the given cycles
  task automatic run(int irq_c, int abt_c, int stt_c);
    bit both;
    both = 0; dc = -1; frd = 0; fa = '0; gated = 1; idle_ok = 0; dw_ok = 0;
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    for (int c = 0; c < 2000; c++) begin
      if (c == 0) begin fa = addr; frd = rd; end
      if (c < 6) pa[c] = addr;
      if (rd && wr) both = 1;
      start = (c == stt_c);
      if (done) begin
        dc = c;
        if (c == irq_c) irq = 1'b1;
        #1;
        chk(done == 1'b1, "R8 done kept under irq", int'(done), 1);
        @(negedge clk);
        irq = 1'b0; start = 1'b0;
        dw_ok = !done && !rd && !wr;
        break;
      end
      if (c == irq_c || c == abt_c) begin
        if (c == irq_c) irq = 1'b1; else abort = 1'b1;
        #1;
        gated = rd || wr;
        @(negedge clk);
        irq = 1'b0; abort = 1'b0; start = 1'b0;
        idle_ok = !rd && !wr && !done;
        break;
      end
      if (wr) mem[addr[11:0]] = wdata;
      @(negedge clk);
    end
    chk(!both, "R3 read and write strobes exclusive", int'(both), 0);
  endtask

  task automatic verify(logic [15:0] src, logic [15:0] dst, logic [15:0] n, string tag);
    int errs;
    logic [15:0] a, b;
    errs = 0;
    for (int i = 0; i <= int'(n); i++) begin
      a = src + 16'(i);
      b = dst + 16'(i);
      if (mem[b[11:0]] !== mem[a[11:0]]) errs++;
    end
    chk(errs == 0, tag, errs, 0);
    b = dst + n + 16'd1;
    chk(mem[b[11:0]] == 8'hEE, "R3 byte past count untouched", int'(mem[b[11:0]]), 'hEE);
  endtask

  task automatic chk_params(logic [15:0] s, logic [7:0] o, string tag);
    int errs;
    errs = 0;
    for (int k = 0; k < 6; k++)
      if (pa[k] !== 16'(s + 16'(o) + 16'(k))) errs++;
    chk(errs == 0, tag, errs, 0);
  endtask

  initial begin
    void'($urandom(32'd20210626));
    for (int i = 0; i < 4096; i++) mem[i] = 8'h00;
    rst_n = 1'b0; start = 0; irq = 0; abort = 0; sp = '0; ofs = '0;
    repeat (3) @(negedge clk);
    chk(!rd && !wr && !done, "R1 strobes low in reset", int'({rd, wr, done}), 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(!rd && !wr && !done, "R1 strobes low after reset", int'({rd, wr, done}), 0);

    // directed basic copy
    setup(16'h0100, 8'h10, 16'd3, 16'h0200, 16'h0300);
    run(-1, -1, -1);
    chk(frd && fa == 16'h0110, "R1 first start fetches params", int'(fa), 'h110);
    chk_params(16'h0100, 8'h10, "R2 parameter address sequence");
    chk(dc == 14, "R4 done cycle count=3", dc, 14);
    chk(dw_ok, "R4 done one cycle then idle", int'(dw_ok), 1);
    verify(16'h0200, 16'h0300, 16'd3, "R3 copy count=3");

    // wraparound of parameter address, single byte
    setup(16'hFFFC, 8'h01, 16'd0, 16'h0220, 16'h0320);
    run(-1, -1, -1);
    chk_params(16'hFFFC, 8'h01, "R9 parameter address wraps");
    chk(pa[3] == 16'h0000, "R9 fourth param at 0000", int'(pa[3]), 0);
    chk(dc == 8, "R4 done cycle count=0", dc, 8);
    verify(16'h0220, 16'h0320, 16'd0, "R3 copy count=0");

    // random transfers
    for (int t = 0; t < 8; t++) begin
      logic [15:0] s, src, dst, n;
      logic [7:0]  o;
      s   = 16'h0800 + 16'(($urandom % 64) * 2);
      o   = 8'($urandom);
      src = 16'h0100 + 16'($urandom % 256);
      dst = 16'h0400 + 16'($urandom % 256);
      n   = 16'($urandom % 32);
      setup(s, o, n, src, dst);
      run(-1, -1, -1);
      chk_params(s, o, "R2 random parameter addresses");
      chk(dc == 6 + 2 * (int'(n) + 1), "R4 random done cycle", dc, 6 + 2 * (int'(n) + 1));
      verify(src, dst, n, "R3 random copy");
    end

    // interrupt during write at count 5, then resume
    setup(16'h0880, 8'h20, 16'd7, 16'h0180, 16'h0480);
    run(11, -1, -1);
    chk(!gated, "R5 write suppressed under irq", int'(gated), 0);
    chk(idle_ok, "R5 idle after irq", int'(idle_ok), 1);
    run(-1, -1, -1);
    chk(frd && fa == 16'h0185, "R5 resume reads source+5", int'(fa), 'h185);
    chk(dc == 12, "R5 resumed done cycle", dc, 12);
    verify(16'h0180, 16'h0480, 16'd7, "R5 resumed copy complete");

    // interrupt during parameter fetch
    setup(16'h0900, 8'h08, 16'd7, 16'h01A0, 16'h04A0);
    run(3, -1, -1);
    chk(!gated, "R6 fetch read suppressed", int'(gated), 0);
    run(-1, -1, -1);
    chk(frd && fa == 16'h0908, "R6 refetch from offset 0", int'(fa), 'h908);
    chk(dc == 22, "R6 full run after refetch", dc, 22);
    verify(16'h01A0, 16'h04A0, 16'd7, "R6 copy after refetch");

    // abort during copy loop
    setup(16'h0940, 8'h30, 16'd7, 16'h01C0, 16'h04C0);
    run(-1, 8, -1);
    chk(!gated && idle_ok, "R7 abort stops engine", int'(gated), 0);
    run(-1, -1, -1);
    chk(frd && fa == 16'h0970, "R7 refetch after abort", int'(fa), 'h970);
    verify(16'h01C0, 16'h04C0, 16'd7, "R7 copy after abort");

    // interrupt on completion cycle, then start must refetch
    setup(16'h0980, 8'h04, 16'd2, 16'h01E0, 16'h04E0);
    run(12, -1, -1);
    chk(dc == 12 && dw_ok, "R8 completion wins over irq", dc, 12);
    run(-1, -1, -1);
    chk(frd && fa == 16'h0984, "R8 resume flag clear after done", int'(fa), 'h984);

    // start pulse while running
    setup(16'h09C0, 8'h00, 16'd5, 16'h0300, 16'h0600);
    run(-1, -1, 9);
    chk(dc == 18, "R10 start mid-run ignored", dc, 18);
    verify(16'h0300, 16'h0600, 16'd5, "R10 copy unaffected");

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog expired act=0 exp=1");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule